// File: doc/BRIEF.md
# Streaming Horizontal Convolution Filter

This block applies a one-dimensional convolution across each image row of a raster-ordered pixel stream. A symmetric window of `TAPS` samples (odd, default 5) is centred on each output position and weighted by a set of signed coefficients. The coefficients are held in a small register bank written through a plain index/data port. Each pixel enters the block once. Only the last `TAPS` samples are kept, in a short shift register, so no line or frame memory is needed.

Every pixel position of every row produces exactly one output. The result for column `c` is emitted as soon as pixel `c+HALF` has arrived, where `HALF = TAPS/2` rounded down. Columns closer than `HALF` to either edge of the row are emitted as zero. After the last pixel of a row, the block stops accepting input and emits the trailing zero columns on its own. Rows are convolved independently: a row's window restarts at its own column 0 and never mixes in samples from the previous row. Row length and frame height come from runtime inputs.

Top module: `hconv_stream`

## Requirements
- R1: For an interior column `c` (with `HALF <= c <= width-1-HALF`), the output equals the sum over tap `t` = 0..TAPS-1 of `coef[t] * pixel[c-HALF+t]`. Pixels are unsigned, coefficients are signed two's complement, and the output is signed two's complement.
- R2: Columns `0..HALF-1` and `width-HALF..width-1` of every row are output as zero.
- R3: Each row is convolved on its own. The first interior column of a row depends only on that row's pixels.
- R4: Each row yields exactly `width` outputs, in column order. After the last pixel of a row is accepted, `inReady` stays low while the trailing border outputs are emitted without further input.
- R5: When `cfgWidth` is below `TAPS`, every output of the row is zero.
- R6: `outEol` is set on the output of column `width-1`. `outSof` is set on column 0 of row 0. The row count returns to 0 after `cfgHeight` rows, so the next frame's first output carries `outSof` even without `inSof`. An input pixel with `inSof` high is treated as column 0 of row 0.
- R7: While `outValid` is high and `outReady` is low, `outData`, `outSof` and `outEol` hold their values and `inReady` is low.
- R8: With `outReady` held high and input always valid, one pixel is accepted per cycle. The only input stalls are the `min(HALF,width)` trailing-border cycles at the end of each row.
- R9: A write with `coefWe` high loads `coefData` into tap `coefIdx`. A write whose index is `TAPS` or above changes no coefficient.
- R10: After reset, `outValid` is 0, `inReady` is 1 and all coefficients are zero.
- R11: The accumulator never overflows. With `TAPS` full-scale pixels (255) and coefficients of -128, the output is exactly `-128*255*TAPS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWidth | input | DIM_W | Pixels per row (at least 1) |
| cfgHeight | input | DIM_W | Rows per frame (at least 1) |
| coefWe | input | 1 | Coefficient write strobe |
| coefIdx | input | IDX_W | Tap index of the write |
| coefData | input | COEF_W | Signed coefficient value |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Block accepts a pixel this cycle |
| inData | input | PIX_W | Unsigned input pixel |
| inSof | input | 1 | Input pixel starts a frame |
| outValid | output | 1 | Output result valid |
| outReady | input | 1 | Downstream accepts the result |
| outData | output | ACC_W | Signed convolution result |
| outSof | output | 1 | Result is row 0, column 0 |
| outEol | output | 1 | Result is the last column of its row |

## Verification
The delicate coincidence is downstream backpressure arriving at a row boundary. The output slot can be released in the same cycle that either the last pixel of a row is accepted or a self-timed border output is produced, and a held result must not be overwritten or lost. The bench provokes this by using periodic and alternating `outReady` patterns on very short rows (widths 1, 4 and 5), so that tail emission and stalls overlap on almost every row. Each emitted result and its flags are judged in order against a model computed from the formula, and a held result is checked for stability on the cycle after every refused transfer.

// File: rtl/hconv_pkg.sv
package hconv_pkg;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic shift;   // a pixel enters the window
    logic load;    // output register takes a new result
    logic useSum;  // result is the window sum (otherwise zero)
    logic sof;     // result is row 0, column 0
    logic eol;     // result is the last column of a row
  } hconv_strobe_t;

endpackage

// File: rtl/hconv_coef_bank.sv
module hconv_coef_bank #(
  parameter int TAPS   = 5,
  parameter int COEF_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [IDX_W-1:0]         wrIdx,
  input  logic [COEF_W-1:0]        wrData,
  output logic [TAPS*COEF_W-1:0]   coefFlat
);

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        coefFlat[t*COEF_W +: COEF_W] <= '0;
      end else if (wrEn && (wrIdx == IDX_W'(t))) begin
        coefFlat[t*COEF_W +: COEF_W] <= wrData;
      end
    end
  end

  // Out-of-range index leaves the bank untouched
  assert_bad_index_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (int'(wrIdx) >= TAPS)) |=> $stable(coefFlat))
    else $error("coefficient changed by out-of-range write");

endmodule

// File: rtl/hconv_ctrl.sv
module hconv_ctrl
  import hconv_pkg::*;
#(
  parameter int TAPS  = 5,
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIM_W-1:0] cfgWidth,
  input  logic [DIM_W-1:0] cfgHeight,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             outValid,
  input  logic             outReady,
  output logic             inReady,
  output hconv_strobe_t    strobe
);

  localparam int HALF = TAPS / 2;
  localparam logic [DIM_W-1:0] ONE_D  = DIM_W'(1);
  localparam logic [DIM_W-1:0] HALF_D = DIM_W'(HALF);
  localparam logic [DIM_W-1:0] EDGE_D = DIM_W'(TAPS - 1);

  logic [DIM_W-1:0] inCol, rowIdx, tailCol;
  logic             tailOn;

  logic [DIM_W-1:0] curCol, curRow, pixCol, emitCol, emitRow, lastCol;
  logic slotFree, inFire, tailFire, pixEmits, lastPix, tailLast;

  always_comb begin
    lastCol  = cfgWidth - ONE_D;
    slotFree = !outValid || outReady;
    inReady  = !tailOn && slotFree;
    inFire   = inValid && inReady;
    tailFire = tailOn && slotFree;
    curCol   = inSof ? '0 : inCol;
    curRow   = inSof ? '0 : rowIdx;
    pixEmits = curCol >= HALF_D;
    pixCol   = curCol - HALF_D;
    lastPix  = curCol == lastCol;
    tailLast = tailCol == lastCol;
    emitCol  = tailOn ? tailCol : pixCol;
    emitRow  = tailOn ? rowIdx : curRow;

    strobe.shift  = inFire;
    strobe.load   = (inFire && pixEmits) || tailFire;
    strobe.useSum = inFire && (curCol >= EDGE_D);
    strobe.sof    = (emitRow == '0) && (emitCol == '0);
    strobe.eol    = emitCol == lastCol;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCol   <= '0;
      rowIdx  <= '0;
      tailCol <= '0;
      tailOn  <= 1'b0;
    end else if (inFire) begin
      rowIdx <= curRow;
      if (lastPix) begin
        inCol   <= '0;
        tailOn  <= 1'b1;
        tailCol <= pixEmits ? (pixCol + ONE_D) : '0;
      end else begin
        inCol <= curCol + ONE_D;
      end
    end else if (tailFire) begin
      if (tailLast) begin
        tailOn  <= 1'b0;
        tailCol <= '0;
        rowIdx  <= (rowIdx == cfgHeight - ONE_D) ? '0 : (rowIdx + ONE_D);
      end else begin
        tailCol <= tailCol + ONE_D;
      end
    end
  end

  assert_tail_blocks_input_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inFire && lastPix) |=> !inReady)
    else $error("input accepted during row tail");

  assert_emit_in_row_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (emitCol < cfgWidth))
    else $error("output column beyond row");

  assert_row_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inFire && lastPix) |=> (inCol == '0))
    else $error("column count not restarted at row end");

  assert_stall_holds_input_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady)
    else $error("input accepted while output is blocked");

endmodule

// File: rtl/hconv_datapath.sv
module hconv_datapath
  import hconv_pkg::*;
#(
  parameter int TAPS   = 5,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  hconv_strobe_t          st,
  input  logic [PIX_W-1:0]       inData,
  input  logic [TAPS*COEF_W-1:0] coefFlat,
  input  logic                   outReady,
  output logic                   outValid,
  output logic [ACC_W-1:0]       outData,
  output logic                   outSof,
  output logic                   outEol
);

  localparam int PROD_W = PIX_W + 1 + COEF_W;

  logic [PIX_W-1:0]         win     [TAPS];
  logic [PIX_W-1:0]         nextWin [TAPS];
  logic signed [PROD_W-1:0] prod    [TAPS];
  logic signed [ACC_W-1:0]  sum;

  // Window after the incoming pixel shifts in: tap 0 oldest, tap TAPS-1 newest
  for (genvar t = 0; t < TAPS; t++) begin : g_win
    if (t < TAPS - 1) begin : g_mid
      assign nextWin[t] = win[t+1];
    end else begin : g_new
      assign nextWin[t] = inData;
    end

    logic signed [COEF_W-1:0] cf;
    logic signed [PIX_W:0]    px;
    assign cf      = coefFlat[t*COEF_W +: COEF_W];
    assign px      = {1'b0, nextWin[t]};
    assign prod[t] = px * cf;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          win[t] <= '0;
      else if (st.shift)  win[t] <= nextWin[t];
    end
  end

  always_comb begin
    sum = '0;
    for (int t = 0; t < TAPS; t++) begin
      sum = sum + {{(ACC_W-PROD_W){prod[t][PROD_W-1]}}, prod[t]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
    end else if (st.load) begin
      outValid <= 1'b1;
      outData  <= st.useSum ? sum : '0;
      outSof   <= st.sof;
      outEol   <= st.eol;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSof) && $stable(outEol)))
    else $error("blocked output changed");

  assert_border_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (st.load && !st.useSum) |=> (outData == '0))
    else $error("border output not zero");

endmodule

// File: rtl/hconv_stream.sv
module hconv_stream
  import hconv_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 5,
  parameter int DIM_W  = 12,
  localparam int IDX_W = $clog2(TAPS),
  localparam int ACC_W = PIX_W + COEF_W + 1 + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIM_W-1:0]  cfgWidth,
  input  logic [DIM_W-1:0]  cfgHeight,
  input  logic              coefWe,
  input  logic [IDX_W-1:0]  coefIdx,
  input  logic [COEF_W-1:0] coefData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [PIX_W-1:0]  inData,
  input  logic              inSof,
  output logic              outValid,
  input  logic              outReady,
  output logic [ACC_W-1:0]  outData,
  output logic              outSof,
  output logic              outEol
);

  hconv_strobe_t           strobe;
  logic [TAPS*COEF_W-1:0]  coefFlat;

  hconv_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W), .IDX_W(IDX_W)) coef_i (
    .clk(clk), .rstN(rstN), .wrEn(coefWe), .wrIdx(coefIdx), .wrData(coefData),
    .coefFlat(coefFlat)
  );

  hconv_ctrl #(.TAPS(TAPS), .DIM_W(DIM_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .inValid(inValid), .inSof(inSof), .outValid(outValid), .outReady(outReady),
    .inReady(inReady), .strobe(strobe)
  );

  hconv_datapath #(.TAPS(TAPS), .PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) dp_i (
    .clk(clk), .rstN(rstN), .st(strobe), .inData(inData), .coefFlat(coefFlat),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outSof(outSof), .outEol(outEol)
  );

endmodule

// File: tb/hconv_stream_tb_top.sv
module hconv_stream_tb_top;
  localparam int PIX_W  = 8;
  localparam int COEF_W = 8;
  localparam int TAPS   = 5;
  localparam int DIM_W  = 12;
  localparam int HALF   = TAPS / 2;
  localparam int IDX_W  = $clog2(TAPS);
  localparam int ACC_W  = PIX_W + COEF_W + 1 + $clog2(TAPS);
  localparam int MAXN   = 256;

  typedef struct packed {
    logic [7:0] width;
    logic [3:0] height;
    logic [1:0] frames;
    logic [1:0] coefSet;
    logic [1:0] readyMode;  // 0 always, 1 alternate, 2 two of three
    logic [1:0] pixMode;    // 0 pattern, 1 full scale
  } case_t;

  localparam case_t CASES [0:6] = '{
    '{8'd8,  4'd2, 2'd1, 2'd0, 2'd0, 2'd0},
    '{8'd10, 4'd3, 2'd2, 2'd1, 2'd1, 2'd0},
    '{8'd5,  4'd2, 2'd1, 2'd2, 2'd2, 2'd0},
    '{8'd4,  4'd2, 2'd1, 2'd0, 2'd1, 2'd0},
    '{8'd1,  4'd2, 2'd2, 2'd1, 2'd2, 2'd0},
    '{8'd12, 4'd1, 2'd1, 2'd3, 2'd0, 2'd1},
    '{8'd7,  4'd2, 2'd1, 2'd2, 2'd2, 2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIM_W-1:0]  cfgWidth = '0;
  logic [DIM_W-1:0]  cfgHeight = '0;
  logic              coefWe = 1'b0;
  logic [IDX_W-1:0]  coefIdx = '0;
  logic [COEF_W-1:0] coefData = '0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [PIX_W-1:0]  inData = '0;
  logic              inSof = 1'b0;
  logic              outValid;
  logic              outReady = 1'b1;
  logic [ACC_W-1:0]  outData;
  logic              outSof, outEol;
  logic signed [ACC_W-1:0] outS;
  assign outS = outData;

  always #5 clk = ~clk;

  hconv_stream #(.PIX_W(PIX_W), .COEF_W(COEF_W), .TAPS(TAPS), .DIM_W(DIM_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .coefWe(coefWe), .coefIdx(coefIdx), .coefData(coefData),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inSof(inSof),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outSof(outSof), .outEol(outEol)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int coefM [TAPS];
  int stimPix [MAXN];
  bit stimSof [MAXN];
  int expData [MAXN];
  bit expSof  [MAXN];
  bit expEol  [MAXN];
  int expCode [MAXN];
  int nStim, nExp, stalls;

  function automatic string reqName(input int code);
    case (code)
      2: return "R2";
      3: return "R3";
      5: return "R5";
      9: return "R9";
      11: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int coefVal(input int set, input int t);
    case (set)
      0: return (t <= HALF) ? t + 1 : TAPS - t;
      1: return (t % 2 == 1) ? -3 - t : 6 - t;
      2: return 9 * t - 20;
      default: return -128;
    endcase
  endfunction

  function automatic int pixVal(input int mode, input int seed, input int r, input int c);
    if (mode == 1) return 255;
    return (seed * 29 + r * 53 + c * 17 + r * c * 3) % 256;
  endfunction

  task automatic writeCoef(input int idx, input int val);
    @(negedge clk);
    coefWe = 1'b1; coefIdx = IDX_W'(idx); coefData = COEF_W'(val);
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  task automatic loadCoefs(input int set);
    for (int t = 0; t < TAPS; t++) begin
      coefM[t] = coefVal(set, t);
      writeCoef(t, coefM[t]);
    end
    // R9: an out-of-range index must leave the set unchanged
    if (TAPS < (1 << IDX_W)) writeCoef(TAPS, 77);
  endtask

  task automatic addFrames(input int w, input int h, input int fr, input int pm,
                           input int seed, input int forceCode);
    for (int f = 0; f < fr; f++)
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++) begin
          int acc = 0;
          bit inner = (c >= HALF) && (c + HALF <= w - 1);
          stimPix[nStim] = pixVal(pm, seed + f, r, c);
          stimSof[nStim] = (f == 0) && (r == 0) && (c == 0);
          nStim++;
          if (inner)
            for (int t = 0; t < TAPS; t++) acc += coefM[t] * pixVal(pm, seed + f, r, c - HALF + t);
          expData[nExp] = acc;
          expSof[nExp]  = (r == 0) && (c == 0);
          expEol[nExp]  = (c == w - 1);
          if (forceCode != 0)       expCode[nExp] = forceCode;
          else if (w < TAPS)        expCode[nExp] = 5;
          else if (!inner)          expCode[nExp] = 2;
          else if (pm == 1)         expCode[nExp] = 11;
          else if (r > 0 && c == HALF) expCode[nExp] = 3;
          else                      expCode[nExp] = 1;
          nExp++;
        end
  endtask

  task automatic runStream(input int readyMode);
    int si = 0, ei = 0, cyc = 0;
    bit held = 1'b0;
    logic [ACC_W-1:0] hData = '0;
    logic hSof = 1'b0, hEol = 1'b0;
    stalls = 0;
    while ((si < nStim || ei < nExp) && cyc < 5000) begin
      @(negedge clk);
      case (readyMode)
        0: outReady = 1'b1;
        1: outReady = (cyc % 2) == 0;
        default: outReady = (cyc % 3) != 1;
      endcase
      if (si < nStim) begin
        inValid = 1'b1; inData = PIX_W'(stimPix[si]); inSof = stimSof[si];
      end else begin
        inValid = 1'b0; inSof = 1'b0;
      end
      #1;
      if (held)
        check(outValid && outData == hData && outSof == hSof && outEol == hEol,
              "R7", "held output changed", longint'(outData), longint'(hData));
      held = outValid && !outReady;
      hData = outData; hSof = outSof; hEol = outEol;
      if (outValid && outReady) begin
        if (ei < nExp) begin
          check(int'(outS) == expData[ei], reqName(expCode[ei]), "output data",
                longint'(outS), longint'(expData[ei]));
          check({outSof, outEol} == {expSof[ei], expEol[ei]}, "R6", "sof/eol flags",
                longint'({outSof, outEol}), longint'({expSof[ei], expEol[ei]}));
        end else begin
          check(1'b0, "R4", "surplus output", longint'(ei), longint'(nExp));
        end
        ei++;
      end
      if (inValid && inReady) si++;
      else if (inValid) stalls++;
      cyc++;
    end
    check(ei == nExp, "R4", "output count", longint'(ei), longint'(nExp));
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; outReady = 1'b1;
    // R4: nothing more appears once the row tails are done
    repeat (4) begin
      @(negedge clk);
      #1;
      check(!outValid, "R4", "output after last column", longint'(outValid), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < TAPS; t++) coefM[t] = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!outValid, "R10", "outValid in reset", longint'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(inReady, "R10", "inReady after reset", longint'(inReady), 1);
    check(!outValid, "R10", "outValid after reset", longint'(outValid), 0);

    // R10 / R9: coefficients reset to zero, out-of-range write ignored
    if (TAPS < (1 << IDX_W)) writeCoef(TAPS, 50);
    cfgWidth = DIM_W'(6); cfgHeight = DIM_W'(1);
    nStim = 0; nExp = 0;
    addFrames(6, 1, 1, 0, 4, 9);
    runStream(0);

    // Vector table walk
    for (int k = 0; k < 7; k++) begin
      int w = int'(CASES[k].width);
      int h = int'(CASES[k].height);
      int fr = int'(CASES[k].frames);
      loadCoefs(int'(CASES[k].coefSet));
      cfgWidth = DIM_W'(w); cfgHeight = DIM_W'(h);
      nStim = 0; nExp = 0;
      addFrames(w, h, fr, int'(CASES[k].pixMode), k + 1, 0);
      runStream(int'(CASES[k].readyMode));
      if (CASES[k].readyMode == 2'd0) begin
        int ex = (fr * h - 1) * ((w < HALF) ? w : HALF);
        check(stalls == ex, "R8", "input stall cycles", longint'(stalls), longint'(ex));
      end
    end

    // R6: inSof in mid-row restarts at column 0 of row 0
    loadCoefs(0);
    cfgWidth = DIM_W'(8); cfgHeight = DIM_W'(2);
    nStim = 0; nExp = 0;
    for (int c = 0; c < 3; c++) begin
      stimPix[nStim] = 200 - c; stimSof[nStim] = (c == 0); nStim++;
    end
    expData[nExp] = 0; expSof[nExp] = 1'b1; expEol[nExp] = 1'b0; expCode[nExp] = 2; nExp++;
    addFrames(8, 1, 1, 0, 11, 0);
    runStream(2);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule